// File: doc/BRIEF.md
# Data Address Unit with Auto-Modifying Pointers

This block forms every data-memory address for an 8-bit core with a 12-bit linear data space. A direct access combines an 8-bit instruction offset with a bank number. The bank is either the fixed access bank or the bank held in a 4-bit bank register, and an access bit in the instruction chooses between them. The unit also holds three 12-bit pointers. Each pointer can reach any byte of the data space.

Each pointer owns five alias addresses near the top of the space. When a direct address lands on one of these aliases, the access is redirected through that pointer. The alias that was hit decides how the address is formed and whether the pointer changes:

- plain use of the pointer,
- post-decrement,
- post-increment,
- pre-increment,
- pointer plus the working register.

An optional extended mode turns the low part of the access bank into a window relative to the third pointer. This lets code reach stack-frame locals. Pointers and the bank register are loaded through a small load port. Data memory, the ALU and instruction decode lie outside this block.

Top module: `dau_unit`

## Requirements
- R1: With the access bit at 1 and no alias hit, the effective address is {bank register, offset}.
- R2: With the access bit at 0 and extended mode off, offsets 0x00–0x5F map to 0x000–0x05F and offsets 0x60–0xFF map to 0xF60–0xFFF.
- R3: With extended mode on and the access bit at 0, offsets 0x00–0x5F give pointer 2 plus the offset, modulo 4096. All other offsets, and every access with the access bit at 1, keep their normal mapping.
- R4: The alias address of pointer p (0..2) in mode m is 0xFD0 + 8·p + m. The modes are m=0 plain, 1 post-decrement, 2 post-increment, 3 pre-increment, 4 indexed. A direct address that hits an alias raises indirect_o. Any other address, including 0xFD5–0xFD7, leaves indirect_o at 0.
- R5: A plain alias yields the pointer as the effective address and leaves the pointer unchanged.
- R6: Post-decrement and post-increment yield the current pointer. After the access the pointer changes by −1 or +1, wrapping modulo 4096.
- R7: Pre-increment yields pointer+1 and leaves the pointer at pointer+1.
- R8: The indexed alias yields the pointer plus the working register, taken as unsigned, modulo 4096. The pointer is unchanged.
- R9: When an indirect access would target an alias address, suppress_o is 1, eff_addr_o still shows that target, and no pointer is modified.
- R10: A load with ld_en_i writes the selected register at the clock edge. Selection 0–2 picks a pointer, and selection 3 picks the bank register, which takes the low 4 bits of the load data. An address formed in the same cycle uses the old value. A load to a pointer wins over that pointer's auto-modify in the same cycle.
- R11: Reset, which is asynchronous and active low, clears all three pointers and the bank register.
- R12: With acc_valid_i low, addresses are still formed, but no pointer is modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | A data access is executed this cycle |
| offset_i | input | 8 | Offset field of the instruction |
| abit_i | input | 1 | Access bit: 0 access bank, 1 bank register |
| ext_mode_i | input | 1 | Enables the frame-relative window |
| wreg_i | input | 8 | Working register, used by the indexed alias |
| ld_en_i | input | 1 | Load strobe |
| ld_sel_i | input | 2 | Load target: 0–2 pointer, 3 bank register |
| ld_data_i | input | 12 | Load value |
| eff_addr_o | output | 12 | Effective data address |
| indirect_o | output | 1 | Access goes through a pointer alias |
| suppress_o | output | 1 | Indirect target is itself an alias; access must be dropped |

## Verification
The case that needs the most care is a load of a pointer in the same cycle as an auto-modifying access through that same pointer. Both want to write the pointer at the same edge.

The bench provokes this by presenting a post-increment alias of pointer 0 together with a load of pointer 0. It then checks that the address of that cycle still shows the old value. In the next cycle a plain access through pointer 0 must show the loaded value, with no increment applied on top.

A load of the bank register during a banked direct access is judged the same way: the old bank appears first, and the new bank appears on the following access.

// File: rtl/dau_pkg.sv
package dau_pkg;
  localparam int MODE_W = 3;
  localparam int NMODE  = 5;

  typedef enum logic [MODE_W-1:0] {
    AM_PLAIN   = 3'd0,
    AM_POSTDEC = 3'd1,
    AM_POSTINC = 3'd2,
    AM_PREINC  = 3'd3,
    AM_INDEX   = 3'd4
  } amode_e;
endpackage

// File: rtl/dau_direct.sv
module dau_direct #(
  parameter int          ADDR_W    = 12,
  parameter int          OFF_W     = 8,
  parameter logic [7:0]  ACC_SPLIT = 8'h60,
  localparam int         BANK_W    = ADDR_W - OFF_W
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              abit_i,
  input  logic              ext_i,
  input  logic [ADDR_W-1:0] frame_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic low_half;
  assign low_half = off_i < OFF_W'(ACC_SPLIT);

  always_comb begin
    if (abit_i)        addr_o = {bank_i, off_i};
    else if (!low_half) addr_o = {{BANK_W{1'b1}}, off_i};
    else if (ext_i)    addr_o = frame_i + ADDR_W'(off_i);
    else               addr_o = ADDR_W'(off_i);
  end
endmodule

// File: rtl/dau_alias_dec.sv
module dau_alias_dec
  import dau_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int NPTR         = 3,
  parameter int ALIAS_BASE   = 'hFD0,
  parameter int ALIAS_STRIDE = 8
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output logic [NPTR*NMODE-1:0] match_o
);
  for (genvar p = 0; p < NPTR; p++) begin : g_p
    for (genvar m = 0; m < NMODE; m++) begin : g_m
      assign match_o[p*NMODE+m] =
        addr_i == ADDR_W'(ALIAS_BASE + p*ALIAS_STRIDE + m);
    end
  end
endmodule

// File: rtl/dau_ptr_file.sv
module dau_ptr_file #(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 4,
  parameter int NPTR   = 3,
  parameter int SEL_W  = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ld_en_i,
  input  logic [SEL_W-1:0]            ld_sel_i,
  input  logic [ADDR_W-1:0]           ld_data_i,
  input  logic                        upd_en_i,
  input  logic [SEL_W-1:0]            upd_sel_i,
  input  logic [ADDR_W-1:0]           upd_val_i,
  output logic [NPTR-1:0][ADDR_W-1:0] ptr_o,
  output logic [BANK_W-1:0]           bank_o
);
  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    logic [ADDR_W-1:0] ptr_q;
    // explicit load outranks auto-modify
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   ptr_q <= '0;
      else if (ld_en_i && ld_sel_i == SEL_W'(p))     ptr_q <= ld_data_i;
      else if (upd_en_i && upd_sel_i == SEL_W'(p))   ptr_q <= upd_val_i;
    end
    assign ptr_o[p] = ptr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  bank_o <= '0;
    else if (ld_en_i && ld_sel_i == SEL_W'(NPTR)) bank_o <= ld_data_i[BANK_W-1:0];
  end
endmodule

// File: rtl/dau_unit.sv
module dau_unit
  import dau_pkg::*;
#(
  parameter int         ADDR_W       = 12,
  parameter int         OFF_W        = 8,
  parameter int         WREG_W       = 8,
  parameter int         NPTR         = 3,
  parameter int         ALIAS_BASE   = 'hFD0,
  parameter int         ALIAS_STRIDE = 8,
  parameter logic [7:0] ACC_SPLIT    = 8'h60,
  localparam int        BANK_W       = ADDR_W - OFF_W,
  localparam int        SEL_W        = $clog2(NPTR + 1),
  localparam int        NALIAS       = NPTR * NMODE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic              abit_i,
  input  logic              ext_mode_i,
  input  logic [WREG_W-1:0] wreg_i,
  input  logic              ld_en_i,
  input  logic [SEL_W-1:0]  ld_sel_i,
  input  logic [ADDR_W-1:0] ld_data_i,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic              indirect_o,
  output logic              suppress_o
);
  logic [NPTR-1:0][ADDR_W-1:0] ptrs;
  logic [BANK_W-1:0]           bank;
  logic [ADDR_W-1:0]           dir_addr, cur_ptr, tgt, nxt;
  logic [NALIAS-1:0]           src_match, tgt_match;
  logic                        ind_hit, tgt_hit, modify, upd_en;
  logic [SEL_W-1:0]            ind_sel;
  amode_e                      ind_mode;

  dau_direct #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ACC_SPLIT(ACC_SPLIT)) u_direct (
    .bank_i (bank),
    .off_i  (offset_i),
    .abit_i (abit_i),
    .ext_i  (ext_mode_i),
    .frame_i(ptrs[NPTR-1]),
    .addr_o (dir_addr)
  );

  dau_alias_dec #(.ADDR_W(ADDR_W), .NPTR(NPTR), .ALIAS_BASE(ALIAS_BASE),
                  .ALIAS_STRIDE(ALIAS_STRIDE)) u_src_dec (
    .addr_i (dir_addr),
    .match_o(src_match)
  );

  always_comb begin
    ind_hit  = 1'b0;
    ind_sel  = '0;
    ind_mode = AM_PLAIN;
    for (int p = 0; p < NPTR; p++) begin
      for (int m = 0; m < NMODE; m++) begin
        if (src_match[p*NMODE+m]) begin
          ind_hit  = 1'b1;
          ind_sel  = SEL_W'(p);
          ind_mode = amode_e'(MODE_W'(m));
        end
      end
    end
  end

  always_comb begin
    cur_ptr = '0;
    for (int p = 0; p < NPTR; p++)
      if (ind_sel == SEL_W'(p)) cur_ptr = ptrs[p];
  end

  always_comb begin
    tgt    = cur_ptr;
    nxt    = cur_ptr;
    modify = 1'b0;
    unique case (ind_mode)
      AM_POSTDEC: begin nxt = cur_ptr - ADDR_W'(1); modify = 1'b1; end
      AM_POSTINC: begin nxt = cur_ptr + ADDR_W'(1); modify = 1'b1; end
      AM_PREINC:  begin tgt = cur_ptr + ADDR_W'(1); nxt = tgt; modify = 1'b1; end
      AM_INDEX:   tgt = cur_ptr + ADDR_W'(wreg_i);
      default:    ;
    endcase
  end

  dau_alias_dec #(.ADDR_W(ADDR_W), .NPTR(NPTR), .ALIAS_BASE(ALIAS_BASE),
                  .ALIAS_STRIDE(ALIAS_STRIDE)) u_tgt_dec (
    .addr_i (tgt),
    .match_o(tgt_match)
  );

  assign tgt_hit = |tgt_match;
  assign upd_en  = acc_valid_i && ind_hit && modify && !tgt_hit;

  dau_ptr_file #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .NPTR(NPTR), .SEL_W(SEL_W)) u_ptr_file (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_en_i  (ld_en_i),
    .ld_sel_i (ld_sel_i),
    .ld_data_i(ld_data_i),
    .upd_en_i (upd_en),
    .upd_sel_i(ind_sel),
    .upd_val_i(nxt),
    .ptr_o    (ptrs),
    .bank_o   (bank)
  );

  assign eff_addr_o = ind_hit ? tgt : dir_addr;
  assign indirect_o = ind_hit;
  assign suppress_o = ind_hit && tgt_hit;
endmodule

// File: rtl/dau_unit_chk.sv
module dau_unit_chk #(
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 8,
  parameter int NPTR   = 3,
  parameter int BANK_W = 4,
  parameter int SEL_W  = 2
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        acc_valid_i,
  input logic                        abit_i,
  input logic [OFF_W-1:0]            offset_i,
  input logic                        ld_en_i,
  input logic [SEL_W-1:0]            ld_sel_i,
  input logic [ADDR_W-1:0]           ld_data_i,
  input logic [ADDR_W-1:0]           eff_addr_o,
  input logic                        indirect_o,
  input logic                        suppress_o,
  input logic [NPTR-1:0][ADDR_W-1:0] ptrs,
  input logic [BANK_W-1:0]           bank
);
  AST_BANKED_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abit_i && !indirect_o |-> eff_addr_o == {bank, offset_i}); // R1

  AST_SUPPRESS_IS_IND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suppress_o |-> indirect_o); // R9

  AST_SUPPRESS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && suppress_o && !ld_en_i |=> $stable(ptrs)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i && !ld_en_i |=> $stable(ptrs)); // R12

  AST_BANK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_en_i && ld_sel_i == SEL_W'(NPTR) |=> bank == $past(ld_data_i[BANK_W-1:0])); // R10

  for (genvar p = 0; p < NPTR; p++) begin : g_ld
    AST_PTR_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_en_i && ld_sel_i == SEL_W'(p) |=> ptrs[p] == $past(ld_data_i)); // R10
  end
endmodule

bind dau_unit dau_unit_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .NPTR(NPTR), .BANK_W(BANK_W), .SEL_W(SEL_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .acc_valid_i(acc_valid_i),
  .abit_i     (abit_i),
  .offset_i   (offset_i),
  .ld_en_i    (ld_en_i),
  .ld_sel_i   (ld_sel_i),
  .ld_data_i  (ld_data_i),
  .eff_addr_o (eff_addr_o),
  .indirect_o (indirect_o),
  .suppress_o (suppress_o),
  .ptrs       (ptrs),
  .bank       (bank)
);

// File: tb/dau_unit_bench.sv
`timescale 1ns/1ps
module dau_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic [7:0]  offset_i = '0;
  logic        abit_i = 1'b0;
  logic        ext_mode_i = 1'b0;
  logic [7:0]  wreg_i = '0;
  logic        ld_en_i = 1'b0;
  logic [1:0]  ld_sel_i = '0;
  logic [11:0] ld_data_i = '0;
  logic [11:0] eff_addr_o;
  logic        indirect_o, suppress_o;

  int errors = 0;
  int checks = 0;

  always #4 clk_i = ~clk_i;

  dau_unit u_dau_unit (.*);

  typedef struct packed {
    logic        ld;
    logic [1:0]  sel;
    logic [11:0] ldd;
    logic        av;
    logic        ab;
    logic        ex;
    logic [7:0]  off;
    logic [7:0]  w;
    logic [11:0] ee;
    logic        ei;
    logic        es;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  // Aliases: p0 D0..D4, p1 D8..DC, p2 E0..E4 (plain, postdec, postinc, preinc, index)
  localparam vec_t VECS [NV] = '{
    '{1'b1,2'd0,12'h123,1'b0,1'b0,1'b0,8'h00,8'h00,12'h000,1'b0,1'b0,4'd2},  // R2, load p0
    '{1'b1,2'd3,12'h005,1'b1,1'b1,1'b0,8'h40,8'h00,12'h040,1'b0,1'b0,4'd10}, // R10 old bank
    '{1'b0,2'd0,12'h000,1'b1,1'b1,1'b0,8'h40,8'h00,12'h540,1'b0,1'b0,4'd1},  // R1
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'h5F,8'h00,12'h05F,1'b0,1'b0,4'd2},  // R2
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'h60,8'h00,12'hF60,1'b0,1'b0,4'd2},  // R2
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'hD0,8'h00,12'h123,1'b1,1'b0,4'd5},  // R5
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'hD2,8'h00,12'h123,1'b1,1'b0,4'd6},  // R6 postinc
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'hD0,8'h00,12'h124,1'b1,1'b0,4'd6},  // R6
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'hD1,8'h00,12'h124,1'b1,1'b0,4'd6},  // R6 postdec
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'hD3,8'h00,12'h124,1'b1,1'b0,4'd7},  // R7
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'hD0,8'h00,12'h124,1'b1,1'b0,4'd7},  // R7
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'hD4,8'hFF,12'h223,1'b1,1'b0,4'd8},  // R8
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'hD0,8'h00,12'h124,1'b1,1'b0,4'd8},  // R8
    '{1'b1,2'd0,12'hFFF,1'b0,1'b0,1'b0,8'h00,8'h00,12'h000,1'b0,1'b0,4'd10}, // R10
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'hD2,8'h00,12'hFFF,1'b1,1'b0,4'd6},  // R6 wrap
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'hD0,8'h00,12'h000,1'b1,1'b0,4'd6},  // R6
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'hD1,8'h00,12'h000,1'b1,1'b0,4'd6},  // R6 wrap
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'hD0,8'h00,12'hFFF,1'b1,1'b0,4'd6},  // R6
    '{1'b1,2'd1,12'hFD2,1'b0,1'b0,1'b0,8'h00,8'h00,12'h000,1'b0,1'b0,4'd10}, // R10
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'hD8,8'h00,12'hFD2,1'b1,1'b1,4'd9},  // R9
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'hDA,8'h00,12'hFD2,1'b1,1'b1,4'd9},  // R9
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'hD8,8'h00,12'hFD2,1'b1,1'b1,4'd9},  // R9 unchanged
    '{1'b1,2'd2,12'h300,1'b0,1'b0,1'b0,8'h00,8'h00,12'h000,1'b0,1'b0,4'd10}, // R10
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b1,8'h10,8'h00,12'h310,1'b0,1'b0,4'd3},  // R3
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b1,8'h60,8'h00,12'hF60,1'b0,1'b0,4'd3},  // R3
    '{1'b0,2'd0,12'h000,1'b1,1'b1,1'b1,8'h10,8'h00,12'h510,1'b0,1'b0,4'd3},  // R3
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'hE0,8'h00,12'h300,1'b1,1'b0,4'd5},  // R5
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'hD5,8'h00,12'hFD5,1'b0,1'b0,4'd4},  // R4
    '{1'b0,2'd0,12'h000,1'b0,1'b0,1'b0,8'hD2,8'h00,12'hFFF,1'b1,1'b0,4'd12}, // R12
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'hD0,8'h00,12'hFFF,1'b1,1'b0,4'd12}, // R12
    '{1'b1,2'd0,12'h050,1'b1,1'b0,1'b0,8'hD2,8'h00,12'hFFF,1'b1,1'b0,4'd10}, // R10 same cycle
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'hD0,8'h00,12'h050,1'b1,1'b0,4'd10}, // R10 load won
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b0,8'hE3,8'h00,12'h301,1'b1,1'b0,4'd7},  // R7
    '{1'b0,2'd0,12'h000,1'b1,1'b0,1'b1,8'h0F,8'h00,12'h310,1'b0,1'b0,4'd3}   // R3
  };

  task automatic check(input string req, input logic [11:0] ee,
                       input logic ei, input logic es);
    checks++;
    if (eff_addr_o !== ee || indirect_o !== ei || suppress_o !== es) begin
      errors++;
      $display("FAIL %s: got addr=%h ind=%b sup=%b, expected addr=%h ind=%b sup=%b",
               req, eff_addr_o, indirect_o, suppress_o, ee, ei, es);
    end
  endtask

  task automatic drive(input logic ld, input logic [1:0] sel, input logic [11:0] ldd,
                       input logic av, input logic ab, input logic ex,
                       input logic [7:0] off, input logic [7:0] w);
    ld_en_i = ld; ld_sel_i = sel; ld_data_i = ldd;
    acc_valid_i = av; abit_i = ab; ext_mode_i = ex; offset_i = off; wreg_i = w;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R11: state while in reset
    #3;
    drive(1'b0, 2'd0, 12'h000, 1'b0, 1'b0, 1'b0, 8'hD0, 8'h00);
    #1 check("R11", 12'h000, 1'b1, 1'b0);
    drive(1'b0, 2'd0, 12'h000, 1'b0, 1'b1, 1'b0, 8'h33, 8'h00);
    #1 check("R11", 12'h033, 1'b0, 1'b0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VECS[i].ld, VECS[i].sel, VECS[i].ldd, VECS[i].av, VECS[i].ab,
            VECS[i].ex, VECS[i].off, VECS[i].w);
      #2 check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].ee, VECS[i].ei, VECS[i].es);
    end

    // R11: asynchronous reset mid-run clears bank and pointers
    @(negedge clk_i);
    drive(1'b0, 2'd0, 12'h000, 1'b0, 1'b1, 1'b0, 8'h40, 8'h00);
    #1 rst_ni = 1'b0;
    #1 check("R11 bank", 12'h040, 1'b0, 1'b0);
    drive(1'b0, 2'd0, 12'h000, 1'b0, 1'b0, 1'b0, 8'hE0, 8'h00);
    #1 check("R11 p2", 12'h000, 1'b1, 1'b0);
    drive(1'b0, 2'd0, 12'h000, 1'b0, 1'b0, 1'b0, 8'hDC, 8'h10);
    #1 check("R11 p1", 12'h010, 1'b1, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R8: indexed wrap past the top of the space
    @(negedge clk_i);
    drive(1'b1, 2'd0, 12'hFF0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    @(negedge clk_i);
    drive(1'b0, 2'd0, 12'h000, 1'b1, 1'b0, 1'b0, 8'hD4, 8'h20);
    #2 check("R8 wrap", 12'h010, 1'b1, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule